// File: doc/BRIEF.md
# Quad I/O Fast-Read Host Engine

This block is the host side of a serial flash read path. A request carries a start address, a byte count and a flag that asks the flash to stay in continuous-read mode. The engine then drives chip select, the serial clock and a four-line data bus. It returns the read bytes one at a time on a valid/ready stream. The serial clock runs at the system clock divided by `2*CLK_DIV`. SCK idles low, the engine launches on the low phase and samples on the rising edge.

The engine records whether the flash was left in continuous-read mode. When it was, the next read starts directly with the address and sends no opcode. The mode byte it sends then decides whether the flash stays in that mode for the read after that. An exit request sends eight all-ones clocks on line 0 inside a chip-select window, and this takes the flash out of continuous-read mode.

Top module: `qspi_quad_reader`

## Requirements
- R1: When the tracked mode is clear, a read frame begins with opcode 0xEB sent MSB first on `sio_o[0]` over 8 serial clocks, with only `sio_oe[0]` enabled.
- R2: After the opcode, or as the first phase when the opcode is skipped, the 24-bit address is sent MSB nibble first on `sio_o[3:0]` over 6 clocks. The mode byte follows over 2 clocks: 0xA0 (bits 5:4 = 2'b10) when `req_cont` is 1, and 0x00 otherwise.
- R3: When `cont_mode` is 1 at acceptance, the frame carries no opcode and starts with the address nibbles.
- R4: After the mode byte, `sio_oe` is 0 for `DUMMY_CLKS-2` clocks and stays 0 until chip select rises. Data nibbles are sampled on rising SCK, high nibble first. Bytes come out in address order.
- R5: A request with `req_len = N-1` yields exactly N bytes. The frame has exactly (opcode 8 or 0) + 6 + `DUMMY_CLKS` + 2N rising SCK edges. Reads that cross the top address keep streaming, and the flash's own wrap to address 0 shows up in the data.
- R6: An exit request produces a frame of exactly 8 clocks with `sio_o[0]`=1 and `sio_oe`=4'b0001, then raises chip select and clears `cont_mode`.
- R7: At the end of a read frame, `cont_mode` takes the value of that request's `req_cont`.
- R8: While `dout_valid` is 1 and `dout_ready` is 0, SCK and `dout_data` hold and `dout_valid` stays 1, so no byte is lost.
- R9: `busy` is 1 exactly while chip select is low. Chip select stays high for at least 2 system clocks between frames.
- R10: When an exit request and a read request arrive in the same cycle, the exit frame runs first and `req_ready` stays 0 while `exit_valid` is 1. The read is then served as a full frame with opcode.
- R11: After reset, chip select is high, SCK is low, every line is released, `dout_valid`, `busy` and `cont_mode` are 0, and `req_ready` is 1.
- R12: SCK is low whenever chip select is high. Every SCK low phase inside a frame lasts exactly `CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Read request accepted this cycle when valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count minus one |
| req_cont | input | 1 | Leave the flash in continuous-read mode after this read |
| exit_valid | input | 1 | Request the continuous-mode exit sequence |
| exit_ready | output | 1 | Exit request accepted this cycle when valid |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| sio_o | output | 4 | Data out to the flash lines |
| sio_oe | output | 4 | Per-line output enable |
| sio_i | input | 4 | Data in from the flash lines |
| dout_data | output | 8 | Read byte |
| dout_valid | output | 1 | Read byte valid |
| dout_ready | input | 1 | Consumer accepts the byte |
| busy | output | 1 | A frame is in progress |
| cont_mode | output | 1 | Flash is tracked as being in continuous-read mode |

## Verification
The exit sequence and a new read compete for the idle engine in the same cycle. The bench raises `exit_valid` and `req_valid` on one edge while the flash is in continuous-read mode. It then checks that the flash model sees an exit frame followed by a read frame with opcode, and that the returned bytes match the requested addresses. A second overlap comes from holding the consumer not-ready while a byte completes: SCK must freeze in that same cycle, including on the final byte, where the raise of chip select has to wait. Random ready patterns provoke this, and the byte stream is compared against a model memory.

// File: rtl/qspi_quad_reader.sv
module qspi_quad_reader #(
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 12,
  parameter int CLK_DIV     = 2,
  parameter int DUMMY_CLKS  = 6,
  parameter int MIN_CS_HIGH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_cont,
  input  logic              exit_valid,
  output logic              exit_ready,
  output logic              cs_n,
  output logic              sck,
  output logic [3:0]        sio_o,
  output logic [3:0]        sio_oe,
  input  logic [3:0]        sio_i,
  output logic [7:0]        dout_data,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic              busy,
  output logic              cont_mode
);
  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int AM_CLKS  = ADDR_NIB + 2;
  localparam int HIZ_CLKS = DUMMY_CLKS - 2;
  localparam int SH_W     = ADDR_W + 16;
  localparam int DIV_W    = $clog2(CLK_DIV) + 1;
  localparam int CNT_W    = $clog2(AM_CLKS + DUMMY_CLKS + MIN_CS_HIGH + 8) + 1;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_AM, S_DUM, S_DATA, S_EXIT, S_GAP} st_t;

  st_t              st;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic [LEN_W-1:0] left;
  logic             hi_nib;
  logic             pend_cont;
  logic [3:0]       nib;

  wire       single    = (st == S_CMD) || (st == S_EXIT);
  wire       active    = (st != S_IDLE) && (st != S_GAP);
  wire       stall     = dout_valid && !dout_ready;
  wire       tick      = active && !stall && (div == DIV_W'(CLK_DIV - 1));
  wire       rise      = tick && !sck;
  wire       fall      = tick && sck;
  wire       last      = (cnt == CNT_W'(1));
  wire       done      = fall && (((st == S_DATA) && hi_nib && (left == '0)) ||
                                  ((st == S_EXIT) && last));
  wire [7:0] mode_byte = req_cont ? 8'hA0 : 8'h00;

  assign sio_o      = single ? {3'b000, sh[SH_W-1]} : sh[SH_W-1 -: 4];
  assign sio_oe     = single ? 4'b0001 : ((st == S_AM) ? 4'b1111 : 4'b0000);
  assign busy       = ~cs_n;
  assign exit_ready = (st == S_IDLE);
  assign req_ready  = exit_ready && !exit_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      div        <= '0;
      cnt        <= '0;
      sh         <= '0;
      left       <= '0;
      hi_nib     <= 1'b1;
      pend_cont  <= 1'b0;
      nib        <= '0;
      cs_n       <= 1'b1;
      sck        <= 1'b0;
      dout_data  <= '0;
      dout_valid <= 1'b0;
      cont_mode  <= 1'b0;
    end else begin
      if (dout_valid && dout_ready) dout_valid <= 1'b0;
      if (active && !stall) div <= tick ? '0 : div + 1'b1;

      if (rise) begin
        sck <= 1'b1;
        if (st == S_DATA) begin
          hi_nib <= ~hi_nib;
          if (hi_nib) nib <= sio_i;
          else begin
            dout_data  <= {nib, sio_i};
            dout_valid <= 1'b1;
          end
        end
      end

      if (fall) begin
        sck <= 1'b0;
        sh  <= single ? (sh << 1) : (sh << 4);
        cnt <= cnt - 1'b1;
        case (st)
          S_CMD:  if (last) begin st <= S_AM; cnt <= CNT_W'(AM_CLKS); end
          S_AM:   if (last) begin
                    st  <= (HIZ_CLKS > 0) ? S_DUM : S_DATA;
                    cnt <= CNT_W'(HIZ_CLKS);
                  end
          S_DUM:  if (last) st <= S_DATA;
          S_DATA: if (hi_nib && left != '0) left <= left - 1'b1;
          default: ;
        endcase
      end

      if (done) begin
        cs_n      <= 1'b1;
        st        <= S_GAP;
        cnt       <= CNT_W'(MIN_CS_HIGH - 2);
        cont_mode <= (st == S_DATA) && pend_cont;
      end

      if (st == S_GAP) begin
        if (cnt == '0) st <= S_IDLE;
        else cnt <= cnt - 1'b1;
      end

      if (st == S_IDLE) begin
        if (exit_valid) begin
          cs_n <= 1'b0;
          st   <= S_EXIT;
          sh   <= {8'hFF, {(SH_W-8){1'b0}}};
          cnt  <= CNT_W'(8);
        end else if (req_valid) begin
          cs_n      <= 1'b0;
          left      <= req_len;
          pend_cont <= req_cont;
          hi_nib    <= 1'b1;
          if (cont_mode) begin
            st  <= S_AM;
            sh  <= {req_addr, mode_byte, 8'h00};
            cnt <= CNT_W'(AM_CLKS);
          end else begin
            st  <= S_CMD;
            sh  <= {8'hEB, req_addr, mode_byte};
            cnt <= CNT_W'(8);
          end
        end
      end
    end
  end
endmodule

// File: rtl/qspi_quad_reader_chk.sv
module qspi_quad_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] sio_oe,
  input logic [7:0] dout_data,
  input logic       dout_valid,
  input logic       dout_ready,
  input logic       exit_valid,
  input logic       req_ready
);
  p_lane_use_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sio_oe != 4'b0000) |-> (sio_oe == 4'b0001 || sio_oe == 4'b1111));

  p_bus_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && $past(sio_oe) == 4'b0000) |-> (sio_oe == 4'b0000));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> ($stable(sck) && $stable(dout_data) && dout_valid));

  p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  p_exit_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |-> !req_ready);

  p_sck_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
endmodule

bind qspi_quad_reader qspi_quad_reader_chk u_chk (.*);

// File: tb/qspi_quad_reader_bench.sv
module qspi_quad_reader_bench;
  localparam int CLK_DIV = 2;
  localparam int DUMMY   = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_cont = 0, exit_valid = 0, dout_ready = 1;
  logic [23:0] req_addr = '0;
  logic [11:0] req_len = '0;
  logic req_ready, exit_ready, cs_n, sck, dout_valid, busy, cont_mode;
  logic [3:0] sio_o, sio_oe;
  logic [3:0] drv = '0;
  logic [7:0] dout_data;

  qspi_quad_reader #(.CLK_DIV(CLK_DIV), .DUMMY_CLKS(DUMMY)) u_qspi_quad_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_cont(req_cont),
    .exit_valid(exit_valid), .exit_ready(exit_ready), .cs_n(cs_n), .sck(sck),
    .sio_o(sio_o), .sio_oe(sio_oe), .sio_i(drv), .dout_data(dout_data),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .busy(busy), .cont_mode(cont_mode));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit stall_en = 0, exp_cont = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input logic [23:0] x);
    return x[7:0] ^ x[15:8] ^ {x[19:16], x[23:20]} ^ 8'h5A;
  endfunction

  // flash model
  int edg = 0, pre = 8, oe_err = 0, last_edges = 0;
  bit dev_cont = 0, frame_cont = 0, ones = 1, last_exit = 0;
  logic [7:0] op = '0, last_op = '0, last_mode = '0;
  logic [31:0] am = '0;
  int frames[$];

  always @(negedge cs_n) begin
    edg = 0; frame_cont = dev_cont; pre = dev_cont ? 0 : 8;
    op = '0; am = '0; ones = 1;
  end

  always @(posedge sck) if (!cs_n) begin
    ones = ones & sio_o[0] & sio_oe[0];
    if (edg < pre) op = {op[6:0], sio_o[0]};
    else if (edg < pre + 8) am = {am[27:0], sio_o};
    else if (sio_oe != 4'b0000) oe_err++;
    edg++;
  end

  always @(negedge sck) if (!cs_n) begin
    if (edg >= pre + 6 + DUMMY) begin
      int k;
      logic [23:0] a;
      logic [7:0] b;
      k = edg - (pre + 6 + DUMMY);
      a = am[31:8] + 24'(k / 2);
      b = mem(a);
      drv = (k % 2 == 0) ? b[7:4] : b[3:0];
    end
  end

  always @(posedge cs_n) begin
    last_edges = edg;
    if (edg == 8 && ones) begin
      last_exit = 1; dev_cont = 0; frames.push_back(1);
    end else begin
      last_exit = 0; last_op = op; last_mode = am[7:0]; frames.push_back(2);
      if (edg >= pre + 8) dev_cont = (am[5:4] == 2'b10);
    end
  end

  // stream collection and monitors
  logic [7:0] rx[$];
  always @(posedge clk) if (rst_n && dout_valid && dout_ready) rx.push_back(dout_data);
  always @(negedge clk) dout_ready <= stall_en ? 1'($urandom_range(0, 1)) : 1'b1;

  int sck_err = 0, busy_err = 0, hold_err = 0, stall_seen = 0, low_run = 0, hi_run = 0, min_gap = 1000;
  bit seen_low = 0, prev_stall = 0, prev_sck = 0;
  logic [7:0] prev_data = '0;
  always @(negedge clk) if (rst_n) begin
    if (!cs_n && !sck) low_run++;
    else begin
      if (low_run != 0 && low_run != CLK_DIV) sck_err++;
      low_run = 0;
    end
    if (cs_n) hi_run++;
    else begin
      if (seen_low && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0; seen_low = 1;
    end
    if (busy != !cs_n) busy_err++;
    if (prev_stall && (dout_data != prev_data || sck != prev_sck)) hold_err++;
    prev_stall = dout_valid && !dout_ready;
    if (prev_stall) stall_seen++;
    prev_data = dout_data; prev_sck = sck;
  end

  task automatic check_bytes(input logic [23:0] a, input int n, input string req);
    int bad = 0;
    chk(rx.size() == n, "R5", "byte count", rx.size(), n);
    foreach (rx[i]) if (rx[i] != mem(a + 24'(i))) bad++;
    chk(bad == 0, req, "byte mismatches", bad, 0);
  endtask

  task automatic do_read(input logic [23:0] a, input int n, input bit c, input bit st);
    bit pc = exp_cont;
    rx.delete(); stall_en = st;
    @(negedge clk); req_addr = a; req_len = 12'(n - 1); req_cont = c; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    wait (cs_n == 1'b1);
    repeat (4) @(negedge clk);
    stall_en = 0;
    check_bytes(a, n, "R4");
    if (pc) chk(last_op == 8'h00, "R3", "opcode skipped", last_op, 0);
    else    chk(last_op == 8'hEB, "R1", "opcode", last_op, 8'hEB);
    chk(last_mode == (c ? 8'hA0 : 8'h00), "R2", "mode byte", last_mode, c ? 8'hA0 : 8'h00);
    chk(last_edges == (pc ? 0 : 8) + 6 + DUMMY + 2 * n, "R5", "clock count",
        last_edges, (pc ? 0 : 8) + 6 + DUMMY + 2 * n);
    chk(cont_mode == c && dev_cont == c, "R7", "tracked mode", cont_mode, c);
    exp_cont = c;
  endtask

  task automatic do_exit();
    @(negedge clk); exit_valid = 1;
    while (!exit_ready) @(negedge clk);
    @(negedge clk); exit_valid = 0;
    wait (cs_n == 1'b1);
    repeat (3) @(negedge clk);
    chk(last_exit && last_edges == 8, "R6", "exit frame clocks", last_edges, 8);
    chk(!cont_mode && !dev_cont, "R6", "mode cleared", cont_mode, 0);
    exp_cont = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(cs_n && !sck && sio_oe == 0, "R11", "bus idle", {cs_n, sck, sio_oe}, 6'h20);
    chk(!dout_valid && !busy && !cont_mode && req_ready, "R11", "flags",
        {dout_valid, busy, cont_mode, req_ready}, 4'b0001);

    do_read(24'h000100, 4, 0, 0);
    do_read(24'h012340, 3, 1, 0);
    do_read(24'h0ABCDE, 5, 1, 0);   // R3 opcode skipped
    do_read(24'hFFFFFD, 6, 0, 0);   // R5 wrap across top
    do_read(24'h00F000, 8, 0, 1);   // R8 stalled consumer
    do_read(24'h000010, 1, 1, 0);
    do_exit();
    do_read(24'h003300, 2, 0, 0);

    // R10 exit and read in the same cycle while continuous
    do_read(24'h040000, 2, 1, 0);
    rx.delete(); frames.delete();
    @(negedge clk);
    exit_valid = 1; req_valid = 1; req_addr = 24'h055550; req_len = 12'd2; req_cont = 0;
    #1 chk(!req_ready, "R10", "read held off", req_ready, 0);
    @(negedge clk); exit_valid = 0;
    chk(!req_ready && !cs_n, "R10", "exit frame running", req_ready, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    wait (cs_n == 1'b1);
    repeat (4) @(negedge clk);
    chk(frames.size() == 2 && frames[0] == 1 && frames[1] == 2, "R10", "frame order",
        frames.size(), 2);
    chk(last_op == 8'hEB, "R10", "read after exit has opcode", last_op, 8'hEB);
    check_bytes(24'h055550, 3, "R10");
    exp_cont = 0;

    for (int i = 0; i < 24; i++) begin
      if ($urandom_range(0, 5) == 0) do_exit();
      else do_read(24'($urandom), $urandom_range(1, 8), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)));
    end

    chk(oe_err == 0, "R4", "lines driven after mode byte", oe_err, 0);
    chk(stall_seen > 0 && hold_err == 0, "R8", "hold while stalled", hold_err, 0);
    chk(busy_err == 0, "R9", "busy vs chip select", busy_err, 0);
    chk(min_gap >= 2, "R9", "chip select high gap", min_gap, 2);
    chk(sck_err == 0, "R12", "sck low phase length", sck_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule